// File: doc/BRIEF.md
# UART Interrupt Mask and Line Router

This block holds the interrupt state of a serial port. Single-cycle set pulses arrive from the receive, transmit, receive-timeout, modem-status and error logic. Each pulse latches a bit in an eleven-bit raw status word, and the bit stays set until software clears it. A software-written enable mask gates the raw word to form the masked status.

Six level interrupt lines are derived from fixed groups of the masked status. There is one line for each source class and one combined line that is high whenever any group is active.

Software reaches the block through a small synchronous register port:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | Enable mask | Loads the mask | Mask |
| 1 | Raw status | Ignored | Raw status |
| 2 | Masked status | Ignored | Masked status |
| 3 | Clear | Write-one-to-clear on the raw status | Zero |
| 4 | Transmit data | Raises the transmit interrupt | Zero |

Reads are combinational. Writes take effect at the clock edge where `reg_wr` is sampled high.

Top module: `uirq_ctrl`

## Requirements
- R1: After synchronous reset, the enable mask and the raw status are zero, and all six interrupt lines are low.
- R2: A 1 on bit k of `src_set` at a clock edge sets raw status bit k. The bit then stays set until it is cleared. Bit layout: 3..0 modem status, 4 receive, 5 transmit, 6 receive timeout, 10..7 error.
- R3: A write to address 0 loads the enable mask. `masked_status` always equals `raw_status` AND mask.
- R4: A write to address 3 clears every raw bit where the written value is 1. All other raw bits keep their value.
- R5: When a set pulse and a clear write hit the same bit at the same edge, the bit ends up set.
- R6: Writes to address 1 (raw status) and address 2 (masked status) change neither the raw status nor the mask.
- R7: `reg_rdata` returns the mask at address 0, the raw status at address 1 and the masked status at address 2. Addresses 3 and 4 and all unused addresses return zero.
- R8: A write to address 4 (transmit data) sets raw bit 5.
- R9: `irq_lines` is mapped as follows: bit 1 follows masked bit 4, bit 2 follows masked bit 5, bit 3 follows masked bit 6, bit 4 is the OR of masked bits 3..0, and bit 5 is the OR of masked bits 10..7. Bit 0 is the OR of all masked bits.
- R10: The status outputs and the interrupt lines show the effect of a write or set pulse directly after the clock edge that samples it. They do not depend combinationally on the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 11 | Per-bit interrupt set pulses from the sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data (combinational) |
| raw_status | output | 11 | Raw interrupt status |
| masked_status | output | 11 | Raw status ANDed with the enable mask |
| irq_lines | output | 6 | Combined, receive, transmit, timeout, modem-status and error lines |

## Verification
Every state change lands at the clock edge that samples the request, so the status outputs and the lines are due one edge after the stimulus. Read data is due within the same cycle as the address change.

The bench drives inputs on the falling edge and removes them at the next falling edge. It compares the outputs at that second falling edge, half a period after the state update, against a reference mask and raw word that it keeps itself. Read data is sampled one time unit after the address is driven, with no intervening clock edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int IRQ_W     = 11;
    localparam int NUM_LINES = 6;
    localparam int ADDR_W    = 3;

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    localparam irq_vec_t GRP_MS  = 11'h00F;
    localparam irq_vec_t GRP_RX  = irq_vec_t'(1) << BIT_RX;
    localparam irq_vec_t GRP_TX  = irq_vec_t'(1) << BIT_TX;
    localparam irq_vec_t GRP_RT  = irq_vec_t'(1) << BIT_RT;
    localparam irq_vec_t GRP_ERR = 11'h780;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK = 3'd0,
        A_RAW  = 3'd1,
        A_MSKD = 3'd2,
        A_CLR  = 3'd3,
        A_DATA = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic     mask_we;
        logic     clr_we;
        logic     data_we;
        irq_vec_t wdata;
    } wr_cmd_t;

    // Group of masked-status bits that feeds output line idx.
    function automatic irq_vec_t line_group(input int idx);
        case (idx)
            0:       return GRP_ERR | GRP_MS | GRP_RT | GRP_TX | GRP_RX;
            1:       return GRP_RX;
            2:       return GRP_TX;
            3:       return GRP_RT;
            4:       return GRP_MS;
            default: return GRP_ERR;
        endcase
    endfunction

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
    import uirq_pkg::*;
(
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  irq_vec_t          reg_wdata,
    output wr_cmd_t           cmd
);

    always_comb begin
        cmd.mask_we = reg_wr && (reg_addr == A_MASK);
        cmd.clr_we  = reg_wr && (reg_addr == A_CLR);
        cmd.data_we = reg_wr && (reg_addr == A_DATA);
        cmd.wdata   = reg_wdata;
    end

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_cmd_t  cmd,
    input  irq_vec_t src_set,
    output irq_vec_t mask_q,
    output irq_vec_t raw_q
);

    irq_vec_t clr_vec;
    irq_vec_t set_vec;
    irq_vec_t raw_d;

    always_comb begin
        clr_vec = cmd.clr_we  ? cmd.wdata : '0;
        set_vec = src_set | (cmd.data_we ? GRP_TX : '0);
        // Set is applied after clear so it wins on a collision.
        raw_d   = (raw_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= raw_d;
            if (cmd.mask_we) mask_q <= cmd.wdata;
        end
    end

    // R2 R5
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_set) |=> ((raw_q & $past(src_set)) == $past(src_set)));

    // R4
    clear_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_we && src_set == '0 && !cmd.data_we) |=> ((raw_q & $past(cmd.wdata)) == '0));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd.mask_we |=> $stable(mask_q));

    // R8
    data_tx_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.data_we |=> raw_q[BIT_TX]);

endmodule

// File: rtl/uirq_route.sv
module uirq_route
    import uirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  irq_vec_t             masked,
    output logic [NUM_LINES-1:0] lines
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam irq_vec_t GRP = line_group(g);
        assign lines[g] = |(masked & GRP);
    end

    // R9
    combined_or_chk: assert property (@(posedge clk) disable iff (rst)
        lines[0] == (|lines[NUM_LINES-1:1]));

    // R9
    rx_line_chk: assert property (@(posedge clk) disable iff (rst)
        lines[1] == masked[BIT_RX]);

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_W-1:0]     src_set,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [IRQ_W-1:0]     reg_wdata,
    output logic [IRQ_W-1:0]     reg_rdata,
    output logic [IRQ_W-1:0]     raw_status,
    output logic [IRQ_W-1:0]     masked_status,
    output logic [NUM_LINES-1:0] irq_lines
);

    wr_cmd_t  cmd;
    irq_vec_t mask_q;
    irq_vec_t raw_q;

    uirq_decode i_decode (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmd       (cmd)
    );

    uirq_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .src_set (src_set),
        .mask_q  (mask_q),
        .raw_q   (raw_q)
    );

    assign raw_status    = raw_q;
    assign masked_status = raw_q & mask_q;

    uirq_route i_route (
        .clk    (clk),
        .rst    (rst),
        .masked (masked_status),
        .lines  (irq_lines)
    );

    always_comb begin
        case (reg_addr)
            A_MASK:  reg_rdata = mask_q;
            A_RAW:   reg_rdata = raw_q;
            A_MSKD:  reg_rdata = masked_status;
            default: reg_rdata = '0;
        endcase
    end

    // R6
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == A_RAW || reg_addr == A_MSKD) && src_set == '0)
            |=> (raw_status == $past(raw_status)));

endmodule

// File: tb/test_uirq_ctrl.sv
module test_uirq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] src_set;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [10:0] reg_wdata;
    logic [10:0] reg_rdata;
    logic [10:0] raw_status;
    logic [10:0] masked_status;
    logic [5:0]  irq_lines;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [10:0] exp_raw;
    logic [10:0] exp_mask;

    always #4 clk = ~clk;

    uirq_ctrl i_uirq_ctrl (
        .clk           (clk),
        .rst           (rst),
        .src_set       (src_set),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .irq_lines     (irq_lines)
    );

    task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] exp_lines(input logic [10:0] m);
        logic [5:0] l;
        l[1] = m[4];
        l[2] = m[5];
        l[3] = m[6];
        l[4] = |m[3:0];
        l[5] = |m[10:7];
        l[0] = |m;
        return l;
    endfunction

    task automatic check_all(input string req);
        chk({req, " raw"}, raw_status, exp_raw);
        chk({req, " masked"}, masked_status, exp_raw & exp_mask);
        chk({req, " lines"}, {5'd0, irq_lines}, {5'd0, exp_lines(exp_raw & exp_mask)});
    endtask

    // One cycle with a register request and set pulses together.
    task automatic cycle(input logic wr, input logic [2:0] a, input logic [10:0] d,
                         input logic [10:0] s);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; src_set = s;
        @(negedge clk);
        reg_wr = 1'b0; src_set = '0; reg_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [10:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cycle(1'b0, 3'd0, '0, '0);
        cycle(1'b0, 3'd0, '0, '0);
        rst = 1'b0;
        exp_raw = '0; exp_mask = '0;
        check_all("R1");
        rd("R1 mask", 3'd0, '0);
    endtask

    task automatic t_set;
        cycle(1'b0, 3'd0, '0, 11'h011);
        exp_raw = 11'h011;
        check_all("R2 pulse");
        cycle(1'b0, 3'd0, '0, '0);
        check_all("R2 sticky");
        cycle(1'b0, 3'd0, '0, 11'h480);
        exp_raw |= 11'h480;
        check_all("R2 error bit");
    endtask

    task automatic t_mask;
        cycle(1'b1, 3'd0, 11'h010, '0);
        exp_mask = 11'h010;
        check_all("R3 rx only");
        rd("R3 read mask", 3'd0, 11'h010);
        cycle(1'b1, 3'd0, 11'h7FF, '0);
        exp_mask = 11'h7FF;
        check_all("R3 all");
    endtask

    task automatic t_clear;
        cycle(1'b1, 3'd3, 11'h401, '0);
        exp_raw &= ~11'h401;
        check_all("R4 partial");
        cycle(1'b1, 3'd3, 11'h7FF, '0);
        exp_raw = '0;
        check_all("R4 all");
    endtask

    task automatic t_collide;
        cycle(1'b1, 3'd3, 11'h7FF, 11'h041);
        exp_raw = 11'h041;
        check_all("R5 set wins");
    endtask

    task automatic t_ignored;
        cycle(1'b1, 3'd1, 11'h000, '0);
        check_all("R6 raw write");
        cycle(1'b1, 3'd2, 11'h7FF, '0);
        check_all("R6 masked write");
        rd("R6 mask kept", 3'd0, exp_mask);
    endtask

    task automatic t_read;
        cycle(1'b1, 3'd0, 11'h00F, '0);
        exp_mask = 11'h00F;
        rd("R7 raw", 3'd1, exp_raw);
        rd("R7 masked", 3'd2, exp_raw & 11'h00F);
        rd("R7 clear reads 0", 3'd3, '0);
        rd("R7 data reads 0", 3'd4, '0);
        rd("R7 unused reads 0", 3'd7, '0);
        check_all("R7 mask ms");
    endtask

    task automatic t_data;
        cycle(1'b1, 3'd3, 11'h7FF, '0);
        exp_raw = '0;
        cycle(1'b1, 3'd0, 11'h020, '0);
        exp_mask = 11'h020;
        cycle(1'b1, 3'd4, 11'h041, '0);
        exp_raw = 11'h020;
        check_all("R8 tx set");
    endtask

    task automatic t_lines;
        logic [10:0] pats [6] = '{11'h008, 11'h010, 11'h020, 11'h040, 11'h100, 11'h000};
        cycle(1'b1, 3'd0, 11'h7FF, '0);
        exp_mask = 11'h7FF;
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, 3'd3, 11'h7FF, '0);
            exp_raw = '0;
            cycle(1'b0, 3'd0, '0, pats[i]);
            exp_raw = pats[i];
            check_all("R9 group");
        end
        // R10: a pulse held only during its cycle must not show early.
        @(negedge clk);
        src_set = 11'h080;
        #1;
        chk("R10 no early", raw_status, exp_raw);
        @(negedge clk);
        src_set = '0;
        exp_raw |= 11'h080;
        check_all("R10 after edge");
    endtask

    initial begin
        src_set = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rst = 1'b1;
        t_reset;
        t_set;
        t_mask;
        t_clear;
        t_collide;
        t_ignored;
        t_read;
        t_data;
        t_lines;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule